// File: doc/BRIEF.md
# Dual-Channel Potentiometer Command Controller

This block sits behind a serial front end that has already matched the device address. It turns the instruction byte that follows into register operations for two digital potentiometer channels. Each channel has an external 8-bit wiper counter, which the block reads and loads. Each channel also has four 8-bit stored setting slots. These slots are modelled as flops and stand in for nonvolatile cells.

The front end gives the block a few pulses: frame open (select falling), one pulse per completed byte, one pulse per step clock while in step mode, and frame close (select rising). With frame close it also gives a flag saying whether the frame stopped part way through a byte. The block answers with the byte the front end should shift out in the next byte slot.

A store into a slot models a slow nonvolatile write. A parameterised cycle timer drives a busy flag, and the host can read that flag through a status command. A write-protect input, active low, blocks stores into the slots.

Top module: `pot_cmd_ctrl`

## Requirements
- R1: The instruction byte carries the opcode in bits 7:4, the slot index in bits 3:2 and the channel in bit 0. Bit 1 must be 0. Opcode 1001 reads the wiper: in the cycle after the instruction byte, tx_byte holds that channel's wiper_q.
- R2: Opcode 1010 loads the selected channel's wiper. The value is the next byte of the frame. wiper_ld pulses for one cycle, the cycle after that byte arrives.
- R3: Opcode 1011 puts the selected slot on tx_byte after the instruction byte. Opcode 1100 stores the next byte into the selected slot. The store happens only at frame close, and only if exactly two bytes were received.
- R4: These opcodes act at frame close, and only if exactly one byte was received. Opcode 1101 loads the channel's wiper from the selected slot. Opcode 1110 stores the channel's wiper value into the selected slot.
- R5: Opcode 0001 loads both wipers at once from their own slot at the selected index. Opcode 1000 stores both wipers into their own slot at the selected index. Both ignore bit 0.
- R6: Opcode 0101 (status) puts {7'b0, nv_busy} on tx_byte after the instruction byte.
- R7: Every accepted slot store raises nv_busy in the cycle after frame close. nv_busy stays high for exactly BUSY_CYC cycles.
- R8: While nv_busy is high, every opcode except status is ignored. This covers reads, which then return 00h.
- R9: When wp_n is low at frame close, no slot store takes place and nv_busy stays low.
- R10: A store is dropped if frame close comes with frm_mid_byte high, or if the byte count is wrong.
- R11: Opcode 0010 enters step mode. Each step_vld pulse loads the channel's wiper with its value plus one if step_up is high, or minus one if step_up is low. The result saturates at FFh and at 00h.
- R12: An unknown opcode, or bit 1 set, makes the frame inert: no load and no store. tx_byte is 00h in every slot that carries no read data.
- R13: After reset, tx_byte is 00h, nv_busy and wiper_ld are low, and all slots hold 00h.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| frm_open | input | 1 | Frame start pulse |
| frm_close | input | 1 | Frame end pulse |
| frm_mid_byte | input | 1 | With frm_close: the frame ended inside a byte |
| byte_vld | input | 1 | A received byte is complete |
| byte_val | input | 8 | The received byte |
| step_vld | input | 1 | Step clock pulse in step mode |
| step_up | input | 1 | Step direction, 1 = up |
| wp_n | input | 1 | Write protect, active low |
| wiper_q | input | 2x8 | Current wiper value of each channel |
| wiper_ld | output | 2 | Load strobe for each channel's wiper |
| wiper_nxt | output | 2x8 | Value to load into each channel's wiper |
| tx_byte | output | 8 | Byte to shift out in the next byte slot |
| nv_busy | output | 1 | A slot store is in progress |

## Verification
The assertions assume the front end raises at most one of frm_open, frm_close, byte_vld and step_vld in any cycle. They also assume frm_mid_byte only matters in the cycle of frm_close. The bench drives each pulse for exactly one cycle through its own tasks, and it never overlaps them. It also lets every store finish its busy window before the next frame, except where it deliberately probes busy behaviour. The wiper counters are modelled in the bench as plain registers that take wiper_nxt on wiper_ld.

// File: rtl/pot_pkg.sv
package pot_pkg;
    localparam int unsigned POT_W    = 8;
    localparam int unsigned POT_NCH  = 2;
    localparam int unsigned POT_NSLT = 4;
    localparam int unsigned POT_IW   = $clog2(POT_NSLT);

    typedef enum logic [3:0] {
        OP_WIPER_RD       = 4'b1001,
        OP_WIPER_WR       = 4'b1010,
        OP_SLOT_RD        = 4'b1011,
        OP_SLOT_WR        = 4'b1100,
        OP_SLOT2WIPER     = 4'b1101,
        OP_WIPER2SLOT     = 4'b1110,
        OP_ALL_SLOT2WIPER = 4'b0001,
        OP_ALL_WIPER2SLOT = 4'b1000,
        OP_STEP           = 4'b0010,
        OP_STATUS         = 4'b0101
    } op_e;

    typedef struct packed {
        logic [1:0]                        cnt;
        logic                              live;
        op_e                               op;
        logic [POT_IW-1:0]                 idx;
        logic                              ch;
        logic [POT_W-1:0]                  data;
        logic [POT_W-1:0]                  tx;
        logic [POT_NCH-1:0]                wld;
        logic [POT_NCH-1:0][POT_W-1:0]     wnxt;
    } ctl_t;
endpackage

// File: rtl/pot_instr_dec.sv
module pot_instr_dec
    import pot_pkg::*;
(
    input  logic [7:0]        instr,
    output op_e               op,
    output logic [POT_IW-1:0] idx,
    output logic              ch,
    output logic              known
);
    always_comb begin
        op    = op_e'(instr[7:4]);
        idx   = instr[3:2];
        ch    = instr[0];
        case (instr[7:4])
            OP_WIPER_RD, OP_WIPER_WR, OP_SLOT_RD, OP_SLOT_WR,
            OP_SLOT2WIPER, OP_WIPER2SLOT, OP_ALL_SLOT2WIPER,
            OP_ALL_WIPER2SLOT, OP_STEP, OP_STATUS: known = ~instr[1];
            default:                               known = 1'b0;
        endcase
    end
endmodule

// File: rtl/pot_slot_bank.sv
module pot_slot_bank
    import pot_pkg::*;
#(
    parameter int unsigned NCH  = POT_NCH,
    parameter int unsigned NSLT = POT_NSLT,
    parameter int unsigned W    = POT_W,
    localparam int unsigned IW  = $clog2(NSLT)
) (
    input  logic                           clk,
    input  logic                           rst_n,
    input  logic [NCH-1:0]                 we,
    input  logic [IW-1:0]                  widx,
    input  logic [NCH-1:0][W-1:0]          wdat,
    output logic [NCH-1:0][NSLT-1:0][W-1:0] q
);
    for (genvar c = 0; c < NCH; c++) begin : g_ch
        logic [NSLT-1:0][W-1:0] mem_d, mem_q;

        always_comb begin
            mem_d = mem_q;
            if (we[c]) mem_d[widx] = wdat[c];
        end

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) mem_q <= '0;
            else        mem_q <= mem_d;
        end

        assign q[c] = mem_q;
    end
endmodule

// File: rtl/pot_busy_tmr.sv
module pot_busy_tmr #(
    parameter int unsigned CYC = 16,
    localparam int unsigned CW = $clog2(CYC + 1)
) (
    input  logic clk,
    input  logic rst_n,
    input  logic start,
    output logic busy
);
    logic [CW-1:0] cnt_d, cnt_q;

    always_comb begin
        cnt_d = cnt_q;
        if (start)            cnt_d = CW'(CYC);
        else if (cnt_q != '0) cnt_d = cnt_q - 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end

    assign busy = (cnt_q != '0);
endmodule

// File: rtl/pot_cmd_ctrl.sv
module pot_cmd_ctrl
    import pot_pkg::*;
#(
    parameter int unsigned BUSY_CYC = 500000
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic                          frm_open,
    input  logic                          frm_close,
    input  logic                          frm_mid_byte,
    input  logic                          byte_vld,
    input  logic [POT_W-1:0]              byte_val,
    input  logic                          step_vld,
    input  logic                          step_up,
    input  logic                          wp_n,
    input  logic [POT_NCH-1:0][POT_W-1:0] wiper_q,
    output logic [POT_NCH-1:0]            wiper_ld,
    output logic [POT_NCH-1:0][POT_W-1:0] wiper_nxt,
    output logic [POT_W-1:0]              tx_byte,
    output logic                          nv_busy
);
    localparam logic [POT_W-1:0] WMAX = '1;

    ctl_t q, d;

    op_e                                  dec_op;
    logic [POT_IW-1:0]                    dec_idx;
    logic                                 dec_ch;
    logic                                 dec_known;

    logic [POT_NCH-1:0]                   nv_we;
    logic [POT_NCH-1:0][POT_W-1:0]        nv_wdat;
    logic [POT_NCH-1:0][POT_NSLT-1:0][POT_W-1:0] nv_q;
    logic                                 tmr_start;
    logic                                 nv_ok;
    logic [POT_W-1:0]                     cur_w;

    pot_instr_dec u_dec (
        .instr (byte_val),
        .op    (dec_op),
        .idx   (dec_idx),
        .ch    (dec_ch),
        .known (dec_known)
    );

    pot_slot_bank #(
        .NCH  (POT_NCH),
        .NSLT (POT_NSLT),
        .W    (POT_W)
    ) u_bank (
        .clk   (clk),
        .rst_n (rst_n),
        .we    (nv_we),
        .widx  (q.idx),
        .wdat  (nv_wdat),
        .q     (nv_q)
    );

    pot_busy_tmr #(
        .CYC (BUSY_CYC)
    ) u_tmr (
        .clk   (clk),
        .rst_n (rst_n),
        .start (tmr_start),
        .busy  (nv_busy)
    );

    assign nv_ok = wp_n & ~frm_mid_byte;
    assign cur_w = wiper_q[q.ch];

    always_comb begin
        d         = q;
        d.wld     = '0;
        nv_we     = '0;
        nv_wdat   = wiper_q;
        tmr_start = 1'b0;

        if (frm_open) begin
            d.cnt  = '0;
            d.live = 1'b0;
            d.tx   = '0;
        end else if (frm_close) begin
            d.live = 1'b0;
            d.tx   = '0;
            if (q.live) begin
                case (q.op)
                    OP_SLOT2WIPER: begin
                        if (q.cnt == 2'd1) begin
                            d.wld[q.ch]  = 1'b1;
                            d.wnxt[q.ch] = nv_q[q.ch][q.idx];
                        end
                    end
                    OP_ALL_SLOT2WIPER: begin
                        if (q.cnt == 2'd1) begin
                            for (int c = 0; c < POT_NCH; c++) begin
                                d.wld[c]  = 1'b1;
                                d.wnxt[c] = nv_q[c][q.idx];
                            end
                        end
                    end
                    OP_WIPER2SLOT: begin
                        if (q.cnt == 2'd1 && nv_ok) nv_we[q.ch] = 1'b1;
                    end
                    OP_ALL_WIPER2SLOT: begin
                        if (q.cnt == 2'd1 && nv_ok) nv_we = '1;
                    end
                    OP_SLOT_WR: begin
                        if (q.cnt == 2'd2 && nv_ok) begin
                            nv_we[q.ch]   = 1'b1;
                            nv_wdat[q.ch] = q.data;
                        end
                    end
                    default: ;
                endcase
            end
            tmr_start = |nv_we;
        end else if (byte_vld) begin
            d.tx = '0;
            if (q.cnt != 2'd3) d.cnt = q.cnt + 2'd1;
            if (q.cnt == 2'd0) begin
                d.op   = dec_op;
                d.idx  = dec_idx;
                d.ch   = dec_ch;
                d.live = dec_known & (~nv_busy | (dec_op == OP_STATUS));
                if (d.live) begin
                    case (dec_op)
                        OP_WIPER_RD: d.tx = wiper_q[dec_ch];
                        OP_SLOT_RD:  d.tx = nv_q[dec_ch][dec_idx];
                        OP_STATUS:   d.tx = {{(POT_W-1){1'b0}}, nv_busy};
                        default:     d.tx = '0;
                    endcase
                end
            end else if (q.cnt == 2'd1 && q.live) begin
                if (q.op == OP_WIPER_WR) begin
                    d.wld[q.ch]  = 1'b1;
                    d.wnxt[q.ch] = byte_val;
                end else if (q.op == OP_SLOT_WR) begin
                    d.data = byte_val;
                end
            end
        end else if (step_vld && q.live && q.op == OP_STEP && q.cnt != 2'd0) begin
            d.wld[q.ch] = 1'b1;
            if (step_up) d.wnxt[q.ch] = (cur_w == WMAX) ? cur_w : cur_w + 1'b1;
            else         d.wnxt[q.ch] = (cur_w == '0)   ? cur_w : cur_w - 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q    <= '0;
            q.op <= OP_STATUS;
        end else begin
            q <= d;
        end
    end

    assign wiper_ld  = q.wld;
    assign wiper_nxt = q.wnxt;
    assign tx_byte   = q.tx;
endmodule

// File: rtl/pot_cmd_ctrl_chk.sv
module pot_cmd_ctrl_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       frm_open,
    input logic       frm_close,
    input logic       frm_mid_byte,
    input logic       byte_vld,
    input logic       step_vld,
    input logic       wp_n,
    input logic [7:0] tx_byte,
    input logic [1:0] wiper_ld,
    input logic       nv_busy
);
    a_r7_busy_starts_at_close: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(nv_busy) |-> $past(frm_close));

    a_r9_busy_needs_wp: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(nv_busy) |-> $past(wp_n));

    a_r10_busy_needs_boundary: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(nv_busy) |-> !$past(frm_mid_byte));

    a_r5_dual_load_at_close: assert property (@(posedge clk) disable iff (!rst_n)
        (wiper_ld == 2'b11) |-> $past(frm_close));

    a_r12_tx_moves_on_events: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(tx_byte) |-> ($past(byte_vld) || $past(frm_open) || $past(frm_close)));

    a_r2_load_has_cause: assert property (@(posedge clk) disable iff (!rst_n)
        (wiper_ld != 2'b00) |-> ($past(byte_vld) || $past(step_vld) || $past(frm_close)));

    a_r11_step_one_channel: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(step_vld) && wiper_ld != 2'b00) |-> ($countones(wiper_ld) == 1));
endmodule

bind pot_cmd_ctrl pot_cmd_ctrl_chk u_chk (.*);

// File: tb/pot_cmd_ctrl_bench.sv
module pot_cmd_ctrl_bench;
    localparam int unsigned BC = 20;

    logic            clk = 1'b0;
    logic            rst_n = 1'b0;
    logic            frm_open = 1'b0, frm_close = 1'b0, frm_mid_byte = 1'b0;
    logic            byte_vld = 1'b0, step_vld = 1'b0, step_up = 1'b0, wp_n = 1'b1;
    logic [7:0]      byte_val = '0;
    logic [1:0][7:0] m_w = '0;
    logic [1:0]      wiper_ld;
    logic [1:0][7:0] wiper_nxt;
    logic [7:0]      tx_byte;
    logic            nv_busy;
    logic [7:0]      m_slot [2][4];
    int              n_run = 0, n_fail = 0;
    bit              done = 0;

    always #2 clk = ~clk;

    pot_cmd_ctrl #(.BUSY_CYC(BC)) u_pot_cmd_ctrl (
        .clk, .rst_n, .frm_open, .frm_close, .frm_mid_byte, .byte_vld, .byte_val,
        .step_vld, .step_up, .wp_n, .wiper_q(m_w), .wiper_ld, .wiper_nxt,
        .tx_byte, .nv_busy
    );

    always @(posedge clk)
        for (int c = 0; c < 2; c++) if (wiper_ld[c]) m_w[c] <= wiper_nxt[c];

    function automatic logic [7:0] ins(logic [3:0] op, logic [1:0] idx, logic ch);
        return {op, idx, 1'b0, ch};
    endfunction

    task automatic check(string req, logic [7:0] act, logic [7:0] exp);
        n_run++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic tick; @(negedge clk); endtask
    task automatic p_open;  frm_open = 1; tick; frm_open = 0; endtask
    task automatic p_byte(logic [7:0] b); byte_vld = 1; byte_val = b; tick; byte_vld = 0; endtask
    task automatic p_close(logic mid); frm_close = 1; frm_mid_byte = mid; tick; frm_close = 0; frm_mid_byte = 0; endtask
    task automatic p_step(logic up); step_vld = 1; step_up = up; tick; step_vld = 0; tick; endtask

    task automatic frame3(logic [7:0] i, logic [7:0] dat, output logic [7:0] rd);
        p_open; p_byte(i); rd = tx_byte; p_byte(dat); p_close(0); tick;
    endtask
    task automatic frame2(logic [7:0] i);
        p_open; p_byte(i); p_close(0); tick;
    endtask
    task automatic wait_idle; repeat (BC + 1) tick; endtask

    task automatic slot_wr(logic ch, logic [1:0] idx, logic [7:0] v);
        logic [7:0] r;
        p_open; p_byte(ins(4'b1100, idx, ch)); p_byte(v); p_close(0);
        check("R7 busy after store", {7'b0, nv_busy}, 8'h01);
        m_slot[ch][idx] = v;
        wait_idle; r = 0;
    endtask

    initial begin
        logic [7:0] r;
        void'($urandom(32'd2024));
        for (int c = 0; c < 2; c++) for (int s = 0; s < 4; s++) m_slot[c][s] = 0;
        repeat (3) tick; rst_n = 1; tick;
        check("R13 tx reset", tx_byte, 8'h00);
        check("R13 busy reset", {7'b0, nv_busy}, 8'h00);
        check("R13 load reset", {6'b0, wiper_ld}, 8'h00);
        frame3(ins(4'b1011, 2'd3, 1), 8'h00, r);
        check("R13 slot reset", r, 8'h00);

        frame3(ins(4'b1010, 0, 0), 8'h5A, r);
        check("R2 wiper write", m_w[0], 8'h5A);
        check("R12 tx zero on write", r, 8'h00);
        frame3(ins(4'b1001, 0, 0), 8'h00, r);
        check("R1 wiper read", r, 8'h5A);

        p_open; p_byte(ins(4'b1100, 2, 1)); p_byte(8'hC3); p_close(0);
        check("R7 busy raised", {7'b0, nv_busy}, 8'h01);
        m_slot[1][2] = 8'hC3;
        frame3(ins(4'b0101, 0, 0), 8'h00, r);
        check("R6 status busy", r, 8'h01);
        frame3(ins(4'b1010, 0, 0), 8'h77, r);
        check("R8 write ignored busy", m_w[0], 8'h5A);
        frame3(ins(4'b1001, 0, 0), 8'h00, r);
        check("R8 read ignored busy", r, 8'h00);
        repeat (BC - 1 - 15) tick;
        check("R7 busy at end", {7'b0, nv_busy}, 8'h01);
        tick;
        check("R7 busy dropped", {7'b0, nv_busy}, 8'h00);
        frame3(ins(4'b0101, 0, 0), 8'h00, r);
        check("R6 status idle", r, 8'h00);
        frame3(ins(4'b1011, 2, 1), 8'h00, r);
        check("R3 slot read", r, 8'hC3);

        p_open; p_byte(ins(4'b1100, 2, 1)); p_byte(8'h11); p_close(1); tick;
        check("R10 mid-byte no busy", {7'b0, nv_busy}, 8'h00);
        p_open; p_byte(ins(4'b1100, 2, 1)); p_close(0); tick;
        check("R10 short no busy", {7'b0, nv_busy}, 8'h00);
        frame3(ins(4'b1011, 2, 1), 8'h00, r);
        check("R10 slot unchanged", r, 8'hC3);

        wp_n = 0;
        p_open; p_byte(ins(4'b1100, 1, 0)); p_byte(8'h99); p_close(0);
        check("R9 protected no busy", {7'b0, nv_busy}, 8'h00);
        tick; wp_n = 1;
        frame3(ins(4'b1011, 1, 0), 8'h00, r);
        check("R9 slot unchanged", r, 8'h00);

        frame2(ins(4'b1101, 2, 1));
        check("R4 slot to wiper", m_w[1], 8'hC3);
        p_open; p_byte(ins(4'b1110, 1, 0)); p_close(0);
        check("R4 store busy", {7'b0, nv_busy}, 8'h01);
        m_slot[0][1] = 8'h5A; wait_idle;
        frame3(ins(4'b1011, 1, 0), 8'h00, r);
        check("R4 wiper to slot", r, 8'h5A);

        frame3(ins(4'b1010, 0, 0), 8'h11, r);
        frame3(ins(4'b1010, 0, 1), 8'h22, r);
        p_open; p_byte(ins(4'b1000, 3, 0)); p_close(0); wait_idle;
        m_slot[0][3] = 8'h11; m_slot[1][3] = 8'h22;
        frame3(ins(4'b1011, 3, 0), 8'h00, r);
        check("R5 global store ch0", r, 8'h11);
        frame3(ins(4'b1011, 3, 1), 8'h00, r);
        check("R5 global store ch1", r, 8'h22);
        frame3(ins(4'b1010, 0, 0), 8'hAA, r);
        frame3(ins(4'b1010, 0, 1), 8'hBB, r);
        frame2(ins(4'b0001, 3, 1));
        check("R5 global load ch0", m_w[0], 8'h11);
        check("R5 global load ch1", m_w[1], 8'h22);

        frame3(ins(4'b1010, 0, 0), 8'hFE, r);
        p_open; p_byte(ins(4'b0010, 0, 0));
        repeat (3) p_step(1);
        check("R11 step saturates high", m_w[0], 8'hFF);
        p_close(0); tick;
        frame3(ins(4'b1010, 0, 1), 8'h01, r);
        p_open; p_byte(ins(4'b0010, 0, 1));
        p_step(0);
        check("R11 step down", m_w[1], 8'h00);
        p_step(0); p_step(0);
        check("R11 step saturates low", m_w[1], 8'h00);
        p_close(0); tick;

        frame3(ins(4'b0110, 0, 0), 8'h33, r);
        check("R12 unknown tx", r, 8'h00);
        check("R12 unknown no load", m_w[0], 8'hFF);
        frame3(8'b1010_0010, 8'h44, r);
        check("R12 reserved bit ignored", m_w[0], 8'hFF);

        for (int k = 0; k < 30; k++) begin
            logic       ch;
            logic [1:0] ix;
            logic [7:0] v;
            ch = 1'($urandom); ix = 2'($urandom); v = 8'($urandom);
            slot_wr(ch, ix, v);
            frame3(ins(4'b1011, ix, ch), 8'h00, r);
            check("R3 random slot", r, m_slot[ch][ix]);
            frame3(ins(4'b1010, 0, ch), v ^ 8'h5A, r);
            frame3(ins(4'b1001, 0, ch), 8'h00, r);
            check("R1 random wiper", r, v ^ 8'h5A);
            frame2(ins(4'b1101, ix, ch));
            check("R4 random restore", m_w[ch], v);
        end

        if (!done) begin
            done = 1;
            $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            done = 1;
            n_run++; n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end
endmodule